// File: doc/BRIEF.md
# Byte-wide Sixteen-Function Arithmetic/Logic Unit

This block is an 8-bit arithmetic and logic unit. It uses the classic irregular four-bit select map, widened to a byte. A mode input picks between sixteen bitwise logic functions and sixteen arithmetic functions. An active-low carry input adds one to any arithmetic result. The block reports the byte result, an active-low carry out of the top bit and a flag that is set when the result is all ones.

The two operands come from two operand registers. Both registers load from one shared byte bus, each with its own load enable. The result path is purely combinational from these registers and the control inputs. Every arithmetic function is formed as a sum of two select-dependent terms plus the carry. Every logic function is formed from the same two terms without a carry chain.

Top module: `alu181_unit`

## Requirements
- R1: While `rst_n` is low and for two clock edges after it rises, both operand registers hold zero. Immediately after reset, with `mode_logic`=1 and `fsel`=4'hF (pass A), or with `fsel`=4'hA (pass B), `result` reads 8'h00.
- R2: On a rising clock edge, `opa` takes `bus_data` when `ld_a`=1, and `opb` takes `bus_data` when `ld_b`=1. A register whose enable is 0 keeps its value, whatever is on the bus.
- R3: With `mode_logic`=1, `fsel` selects the following functions of A (`opa`) and B (`opb`):
  - 0: ~A
  - 1: ~(A|B)
  - 2: ~A&B
  - 3: 0
  - 4: ~(A&B)
  - 5: ~B
  - 6: A^B
  - 7: A&~B
  - 8: ~A|B
  - 9: ~(A^B)
  - A: B
  - B: A&B
  - C: all ones
  - D: A|~B
  - E: A|B
  - F: A
- R4: With `mode_logic`=0 and `carry_n`=1, `fsel` selects the following functions, each modulo 256:
  - 0: A
  - 1: A|B
  - 2: A|~B
  - 3: 8'hFF
  - 4: A+(A&~B)
  - 5: (A|B)+(A&~B)
  - 6: A-B-1
  - 7: (A&~B)-1
  - 8: A+(A&B)
  - 9: A+B
  - A: (A|~B)+(A&B)
  - B: (A&B)-1
  - C: A+A
  - D: (A|B)+A
  - E: (A|~B)+A
  - F: A-1
- R5: With `mode_logic`=0 and `carry_n`=0, `result` is the R4 value plus one, modulo 256. For example, `fsel`=6 gives A-B and `fsel`=0 gives A+1.
- R6: In arithmetic mode, `carry_out_n` is 0 exactly when the 9-bit sum of the two terms of R4 plus the carry overflows bit 7. For the "minus one" forms, this treats -1 as an addend of 8'hFF. For A-B-1 it treats the addend as ~B.
- R7: With `mode_logic`=1, `carry_out_n` is 1, and `carry_n` has no effect on `result`.
- R8: `all_ones` is 1 exactly when `result` is 8'hFF. With `mode_logic`=0, `fsel`=6 and `carry_n`=1, it is therefore 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_data | input | 8 | Shared byte bus feeding both operand registers |
| ld_a | input | 1 | Load enable of operand register A |
| ld_b | input | 1 | Load enable of operand register B |
| mode_logic | input | 1 | 1 = logic functions, 0 = arithmetic functions |
| carry_n | input | 1 | Active-low carry in (0 adds one) |
| fsel | input | 4 | Function select |
| result | output | 8 | Function result |
| carry_out_n | output | 1 | Active-low carry out of bit 7, 1 in logic mode |
| all_ones | output | 1 | Set when every result bit is 1 |

## Verification
The hardest case to reach is a carry out of bit 7 on the "minus one" and mixed-term functions. Whether it appears there depends on the exact bit pattern of both operands, not only on their size. The stimulus loads every pairing of the boundary bytes 8'h00, 8'hFF, 8'h80 and 8'h7F, plus random pairs. For each pair it sweeps all 48 combinations of mode, select and carry. Equal-operand pairs are included so that the all-ones flag is driven by the subtract form.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned SEL_W = 4;
  typedef logic [SEL_W-1:0] fsel_t;
  localparam fsel_t SEL_PASS_A = 4'hF;
  localparam fsel_t SEL_PASS_B = 4'hA;
  localparam fsel_t SEL_SUB    = 4'h6;
  localparam fsel_t SEL_FIRST  = 4'h0;
endpackage

// File: rtl/alu_oper_reg.sv
module alu_oper_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/alu_term_gen.sv
module alu_term_gen #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  alu_pkg::fsel_t       fsel,
  output logic [W-1:0]         x,
  output logic [W-1:0]         y
);
  // Per-bit propagate-style term x and generate-style term y
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      x[i] = a[i] | (b[i] & fsel[0]) | (~b[i] & fsel[1]);
      y[i] = (a[i] & b[i] & fsel[3]) | (a[i] & ~b[i] & fsel[2]);
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         mode_logic,
  input  logic         carry_n,
  output logic [W-1:0] f,
  output logic         cout_n,
  output logic         ones
);
  localparam int unsigned SW = W + 1;
  logic [SW-1:0] sum;
  logic [SW-1:0] cin_ext;
  logic [W-1:0]  lgc;

  always_comb begin
    cin_ext = {{W{1'b0}}, ~carry_n};
    sum     = {1'b0, x} + {1'b0, y} + cin_ext;
    lgc     = ~(x ^ y);
    if (mode_logic) begin
      f      = lgc;
      cout_n = 1'b1;
    end else begin
      f      = sum[W-1:0];
      cout_n = ~sum[W];
    end
    ones = &f;
  end
endmodule

// File: rtl/alu181_unit.sv
module alu181_unit #(
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         bus_data,
  input  logic                 ld_a,
  input  logic                 ld_b,
  input  logic                 mode_logic,
  input  logic                 carry_n,
  input  logic [3:0]           fsel,
  output logic [W-1:0]         result,
  output logic                 carry_out_n,
  output logic                 all_ones
);
  import alu_pkg::*;

  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic         rst_meta_n, rst_sync_n;
  logic [W-1:0] opa, opb, tx, ty;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  alu_oper_reg #(.W(W)) i_reg_a (
    .clk(clk), .rst_n(rst_sync_n), .load(ld_a), .d(bus_data), .q(opa)
  );
  alu_oper_reg #(.W(W)) i_reg_b (
    .clk(clk), .rst_n(rst_sync_n), .load(ld_b), .d(bus_data), .q(opb)
  );

  p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_a |=> (opa == $past(bus_data)));
  p_hold_b_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld_b |=> $stable(opb));

  alu_term_gen #(.W(W)) i_terms (
    .a(opa), .b(opb), .fsel(fsel), .x(tx), .y(ty)
  );

  alu_core #(.W(W)) i_core (
    .x(tx), .y(ty), .mode_logic(mode_logic), .carry_n(carry_n),
    .f(result), .cout_n(carry_out_n), .ones(all_ones)
  );

  p_pass_a_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_logic && fsel == SEL_PASS_A) |-> (result == opa));
  p_incr_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_logic && !carry_n && fsel == SEL_FIRST) |-> (result == opa + 1'b1));
  p_incr_cout_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_logic && !carry_n && fsel == SEL_FIRST) |-> (carry_out_n == (opa != ALL1)));
  p_logic_cout_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_logic |-> carry_out_n);
  p_equal_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_logic && carry_n && fsel == SEL_SUB) |-> (all_ones == (opa == opb)));
endmodule

// File: tb/test_alu181_unit.sv
module test_alu181_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_data;
  logic       ld_a, ld_b, mode_logic, carry_n;
  logic [3:0] fsel;
  logic [7:0] result;
  logic       carry_out_n, all_ones;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  alu181_unit i_alu181_unit (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .ld_a(ld_a), .ld_b(ld_b),
    .mode_logic(mode_logic), .carry_n(carry_n), .fsel(fsel),
    .result(result), .carry_out_n(carry_out_n), .all_ones(all_ones)
  );

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  // Reference: {carry_out_n, result} from the function table
  function automatic logic [8:0] ref_fn(input logic [7:0] a, input logic [7:0] b,
                                        input logic m, input logic [3:0] s,
                                        input logic cn);
    logic [8:0] p, q, t;
    logic [7:0] l;
    if (m) begin
      case (s)
        4'h0: l = ~a;        4'h1: l = ~(a | b);
        4'h2: l = ~a & b;    4'h3: l = 8'h00;
        4'h4: l = ~(a & b);  4'h5: l = ~b;
        4'h6: l = a ^ b;     4'h7: l = a & ~b;
        4'h8: l = ~a | b;    4'h9: l = ~(a ^ b);
        4'hA: l = b;         4'hB: l = a & b;
        4'hC: l = 8'hFF;     4'hD: l = a | ~b;
        4'hE: l = a | b;     default: l = a;
      endcase
      return {1'b1, l};
    end
    case (s)
      4'h0: begin p = {1'b0, a};      q = 9'h0; end
      4'h1: begin p = {1'b0, a | b};  q = 9'h0; end
      4'h2: begin p = {1'b0, a | ~b}; q = 9'h0; end
      4'h3: begin p = 9'h0FF;         q = 9'h0; end
      4'h4: begin p = {1'b0, a};      q = {1'b0, a & ~b}; end
      4'h5: begin p = {1'b0, a | b};  q = {1'b0, a & ~b}; end
      4'h6: begin p = {1'b0, a};      q = {1'b0, ~b}; end
      4'h7: begin p = {1'b0, a & ~b}; q = 9'h0FF; end
      4'h8: begin p = {1'b0, a};      q = {1'b0, a & b}; end
      4'h9: begin p = {1'b0, a};      q = {1'b0, b}; end
      4'hA: begin p = {1'b0, a | ~b}; q = {1'b0, a & b}; end
      4'hB: begin p = {1'b0, a & b};  q = 9'h0FF; end
      4'hC: begin p = {1'b0, a};      q = {1'b0, a}; end
      4'hD: begin p = {1'b0, a | b};  q = {1'b0, a}; end
      4'hE: begin p = {1'b0, a | ~b}; q = {1'b0, a}; end
      default: begin p = {1'b0, a};   q = 9'h0FF; end
    endcase
    t = p + q + {8'h0, ~cn};
    return {~t[8], t[7:0]};
  endfunction

  task automatic load_pair(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); bus_data = a; ld_a = 1'b1; ld_b = 1'b0;
    @(negedge clk); bus_data = b; ld_a = 1'b0; ld_b = 1'b1;
    @(negedge clk); ld_b = 1'b0; bus_data = ~b;
  endtask

  task automatic sweep(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] e;
    load_pair(a, b);
    for (int k = 0; k < 48; k++) begin
      mode_logic = (k >= 32);
      carry_n    = (k >= 32) ? k[4] : ~k[4];
      fsel       = k[3:0];
      #1;
      e = ref_fn(a, b, mode_logic, fsel, carry_n);
      if (mode_logic) begin
        check("R3 logic result", result, e[7:0]);
        check("R7 logic carry_out_n", carry_out_n, 1);
      end else if (carry_n) begin
        check("R4 arith result", result, e[7:0]);
        check("R6 carry_out_n", carry_out_n, e[8]);
      end else begin
        check("R5 arith+1 result", result, e[7:0]);
        check("R6 carry_out_n (cin)", carry_out_n, e[8]);
      end
      check("R8 all_ones", all_ones, (e[7:0] == 8'hFF));
    end
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] edges [4];
    logic [7:0] ra, rb;
    logic [7:0] keep;
    edges[0] = 8'h00; edges[1] = 8'hFF; edges[2] = 8'h80; edges[3] = 8'h7F;
    rst_n = 1'b0; bus_data = 8'h5A; ld_a = 1'b0; ld_b = 1'b0;
    mode_logic = 1'b1; carry_n = 1'b1; fsel = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset opa", result, 8'h00);
    fsel = 4'hA; #1;
    check("R1 reset opb", result, 8'h00);

    // R2: load, then bus changes without enable
    load_pair(8'h3C, 8'hC5);
    @(negedge clk); bus_data = 8'h99;
    @(negedge clk);
    mode_logic = 1'b1; fsel = 4'hF; #1;
    check("R2 hold opa", result, 8'h3C);
    fsel = 4'hA; #1;
    check("R2 hold opb", result, 8'hC5);

    // R7: carry_n has no effect in logic mode
    for (int s = 0; s < 16; s++) begin
      fsel = s[3:0]; carry_n = 1'b1; #1;
      keep = result;
      carry_n = 1'b0; #1;
      check("R7 carry ignored in logic", result, keep);
    end

    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        sweep(edges[i], edges[j]);
    for (int n = 0; n < 24; n++) begin
      ra = 8'($urandom);
      rb = (n % 4 == 0) ? ra : 8'($urandom);
      sweep(ra, rb);
    end

    // R8: equality flag on subtract form
    load_pair(8'h42, 8'h42);
    mode_logic = 1'b0; carry_n = 1'b1; fsel = 4'h6; #1;
    check("R8 equal operands", all_ones, 1);
    load_pair(8'h42, 8'h43);
    mode_logic = 1'b0; carry_n = 1'b1; fsel = 4'h6; #1;
    check("R8 unequal operands", all_ones, 0);

    finish_run();
  end
endmodule